// File: doc/BRIEF.md
# 64-bit SEC-DED ECC codec

This block protects 64-bit memory words with eight check bits. It has two independent combinational paths. The write path takes a data word and produces its check byte. The read path takes a stored word and its stored check byte and rebuilds the check byte from the data. It XORs the rebuilt byte with the stored one to form a syndrome, and sorts that syndrome into one of four outcomes: clean, one bit flipped, two bits flipped, or three or more bits flipped.

A single flipped data bit is inverted back when correction is enabled. A single flipped check bit leaves the data untouched. Turning correction off gives a detect-only path in which the data always passes through as read. A parity bit is produced for each byte of the outgoing data, with even or odd sense chosen by an input.

The code is arranged so that an all-zero word has a nonzero check byte. Every data column of the parity-check matrix has odd weight of three or more, and every check column has weight one. With that arrangement, the weight of the syndrome alone separates double errors from the wider multi-bit cases. The block has no clock. Every output follows its inputs within the same cycle and nothing is held.

Top module: `secded64_codec`

## Requirements
- R1: Data bit i owns column C(i), which is the i-th (counting from 0) 8-bit value, in ascending numeric order, whose popcount is odd and at least 3. Check bit k of `wr_check_o` is the XOR of every data bit i for which bit k of C(i) is 1, then inverted when k is 2 or 3.
- R2: An all-zero write word yields the check byte 0x0C.
- R3: `syndrome_o` equals the check byte rebuilt from `rd_data_i` (by the R1 rule) XOR `rd_check_i`. A zero syndrome gives `err_o`=0, `merr_o`=0, `dbl_o`=0, `multi_o`=0 and `data_o`=`rd_data_i`.
- R4: When the syndrome equals C(i), the result is `err_o`=1 and `merr_o`=0. With `correct_en_i`=1, `data_o` is `rd_data_i` with bit i inverted.
- R5: When the syndrome has exactly one bit set (a check bit in error), the result is `err_o`=1 and `merr_o`=0, and `data_o`=`rd_data_i`.
- R6: A nonzero syndrome of even popcount gives `err_o`=1, `merr_o`=1, `dbl_o`=1 and `multi_o`=0, and `data_o`=`rd_data_i`.
- R7: A syndrome of odd popcount of at least 3 that equals no C(i) gives `err_o`=1, `merr_o`=1, `multi_o`=1 and `dbl_o`=0, and `data_o`=`rd_data_i`.
- R8: With `correct_en_i`=0, `data_o` always equals `rd_data_i`, and the flags and syndrome are the same as with correction enabled.
- R9: `parity_o[b]` is the XOR of `data_o[8b+7:8b]` when `parity_odd_i`=0, and that XOR inverted when `parity_odd_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data_i | input | 64 | Word to be written |
| wr_check_o | output | 8 | Check byte for wr_data_i |
| rd_data_i | input | 64 | Word read from memory |
| rd_check_i | input | 8 | Check byte read from memory |
| correct_en_i | input | 1 | 1 = correct single data errors, 0 = detect only |
| parity_odd_i | input | 1 | 1 = odd byte parity, 0 = even |
| data_o | output | 64 | Read word after optional correction |
| parity_o | output | 8 | Per-byte parity of data_o |
| syndrome_o | output | 8 | Rebuilt check byte XOR stored check byte |
| err_o | output | 1 | Any error detected |
| merr_o | output | 1 | Uncorrectable error (double or wider) |
| dbl_o | output | 1 | Double-bit error class |
| multi_o | output | 1 | Three-or-more-bit error class |

## Verification
The block holds no state, so a fault in the column table or in the classifier shows up at the ports for the same input vector that touches it. A wrong column entry changes both the write check byte and the data bit that gets corrected. A wrong classification flips `merr_o`, `dbl_o` or `multi_o`, and can also let data change when it should have passed through. The bench drives all 256 syndromes on several data patterns, in both correction modes and both parity senses. It also flips every single data bit and a set of data-bit pairs, so any such fault is seen on the first vector that hits it.

// File: rtl/secded64_pkg.sv
package secded64_pkg;

  localparam int MAX_CW = 16;
  localparam int MAX_DW = 128;

  // number of set bits in a check-sized value
  function automatic int ones(input logic [MAX_CW-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < MAX_CW; b++) n += int'(v[b]);
    return n;
  endfunction

  // column of data bit idx: idx-th ascending value of odd weight >= 3
  function automatic logic [MAX_CW-1:0] code_col(input int idx, input int cw);
    int seen;
    int w;
    logic [MAX_CW-1:0] cand;
    logic [MAX_CW-1:0] res;
    seen = 0;
    res  = '0;
    for (int v = 0; v < (1 << cw); v++) begin
      cand = v[MAX_CW-1:0];
      w    = ones(cand);
      if (w >= 3 && (w % 2) == 1) begin
        if (seen == idx) res = cand;
        seen++;
      end
    end
    return res;
  endfunction

  // data bits feeding one check row
  function automatic logic [MAX_DW-1:0] row_taps(input int row, input int dw, input int cw);
    logic [MAX_DW-1:0] m;
    logic [MAX_CW-1:0] c;
    m = '0;
    for (int i = 0; i < dw; i++) begin
      c    = code_col(i, cw);
      m[i] = c[row];
    end
    return m;
  endfunction

  // parity bit of one byte with selectable sense
  function automatic logic byte_par(input logic [7:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

endpackage

// File: rtl/secded64_enc.sv
module secded64_enc
  import secded64_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8,
  parameter logic [CW-1:0] INV = 8'h0C
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);

  for (genvar k = 0; k < CW; k++) begin : g_row
    localparam logic [MAX_DW-1:0] TAPS = row_taps(k, DW, CW);
    assign check_o[k] = (^(data_i & TAPS[DW-1:0])) ^ INV[k];
  end

endmodule

// File: rtl/secded64_dec.sv
module secded64_dec
  import secded64_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [CW-1:0] syn_i,
  output logic [DW-1:0] hit_o,
  output logic          single_data_o,
  output logic          single_chk_o,
  output logic          dbl_o,
  output logic          multi_o
);

  logic syn_nz;
  logic syn_odd;

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [MAX_CW-1:0] COLF = code_col(i, CW);
    assign hit_o[i] = (syn_i == COLF[CW-1:0]);
  end

  assign syn_nz        = |syn_i;
  assign syn_odd       = ^syn_i;
  assign single_data_o = |hit_o;
  assign single_chk_o  = ($countones(syn_i) == 1);
  assign dbl_o         = syn_nz & ~syn_odd;
  assign multi_o       = syn_odd & ~single_data_o & ~single_chk_o;

  always_comb begin
    // R4
    one_col_chk: assert ($onehot0(hit_o));
    // R6
    class_excl_chk: assert ($onehot0({single_data_o, single_chk_o, dbl_o, multi_o}));
    // R3
    if (syn_nz) begin
      class_cover_chk: assert ($countones({single_data_o, single_chk_o, dbl_o, multi_o}) == 1);
    end
    // R4
    if (single_data_o) begin
      data_col_odd_chk: assert (syn_odd && $countones(syn_i) >= 3);
    end
  end

endmodule

// File: rtl/secded64_fix.sv
module secded64_fix
  import secded64_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]    rd_data_i,
  input  logic [DW-1:0]    hit_i,
  input  logic             correct_en_i,
  input  logic             merr_i,
  input  logic             parity_odd_i,
  output logic [DW-1:0]    data_o,
  output logic [DW/8-1:0]  parity_o
);

  localparam int NB = DW / 8;

  logic [DW-1:0] flip;

  assign flip   = (correct_en_i && !merr_i) ? hit_i : '0;
  assign data_o = rd_data_i ^ flip;

  for (genvar b = 0; b < NB; b++) begin : g_par
    assign parity_o[b] = byte_par(data_o[b*8 +: 8], parity_odd_i);
  end

  always_comb begin
    // R4
    at_most_one_flip_chk: assert ($countones(data_o ^ rd_data_i) <= 1);
    // R7
    if (merr_i) begin
      merr_pass_chk: assert (data_o == rd_data_i);
    end
  end

endmodule

// File: rtl/secded64_codec.sv
module secded64_codec
  import secded64_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8,
  parameter logic [CW-1:0] INV = 8'h0C
) (
  input  logic [DW-1:0]   wr_data_i,
  output logic [CW-1:0]   wr_check_o,
  input  logic [DW-1:0]   rd_data_i,
  input  logic [CW-1:0]   rd_check_i,
  input  logic            correct_en_i,
  input  logic            parity_odd_i,
  output logic [DW-1:0]   data_o,
  output logic [DW/8-1:0] parity_o,
  output logic [CW-1:0]   syndrome_o,
  output logic            err_o,
  output logic            merr_o,
  output logic            dbl_o,
  output logic            multi_o
);

  logic [CW-1:0] regen;
  logic [DW-1:0] hit;
  logic          single_data;
  logic          single_chk;

  secded64_enc #(.DW(DW), .CW(CW), .INV(INV)) u_wr_enc (
    .data_i  (wr_data_i),
    .check_o (wr_check_o)
  );

  secded64_enc #(.DW(DW), .CW(CW), .INV(INV)) u_rd_enc (
    .data_i  (rd_data_i),
    .check_o (regen)
  );

  assign syndrome_o = regen ^ rd_check_i;

  secded64_dec #(.DW(DW), .CW(CW)) u_dec (
    .syn_i         (syndrome_o),
    .hit_o         (hit),
    .single_data_o (single_data),
    .single_chk_o  (single_chk),
    .dbl_o         (dbl_o),
    .multi_o       (multi_o)
  );

  assign err_o  = |syndrome_o;
  assign merr_o = dbl_o | multi_o;

  secded64_fix #(.DW(DW)) u_fix (
    .rd_data_i    (rd_data_i),
    .hit_i        (hit),
    .correct_en_i (correct_en_i),
    .merr_i       (merr_o),
    .parity_odd_i (parity_odd_i),
    .data_o       (data_o),
    .parity_o     (parity_o)
  );

  always_comb begin
    // R3
    if (!err_o) begin
      clean_pass_chk: assert (data_o == rd_data_i && !merr_o);
    end
    // R8
    if (!correct_en_i) begin
      detect_only_chk: assert (data_o == rd_data_i);
    end
    // R5
    if (single_chk) begin
      chk_bit_only_chk: assert (data_o == rd_data_i && err_o && !merr_o);
    end
    // R4
    if (single_data && correct_en_i) begin
      fix_one_chk: assert ($countones(data_o ^ rd_data_i) == 1);
    end
  end

endmodule

// File: tb/secded64_codec_bench.sv
module secded64_codec_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] wr_data, rd_data, data_o;
  logic [7:0]  wr_check, rd_check, parity, syndrome;
  logic        ce, podd, err, merr, dbl, multi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] cols [64];

  secded64_codec u_secded64_codec (
    .wr_data_i    (wr_data),
    .wr_check_o   (wr_check),
    .rd_data_i    (rd_data),
    .rd_check_i   (rd_check),
    .correct_en_i (ce),
    .parity_odd_i (podd),
    .data_o       (data_o),
    .parity_o     (parity),
    .syndrome_o   (syndrome),
    .err_o        (err),
    .merr_o       (merr),
    .dbl_o        (dbl),
    .multi_o      (multi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // column-wise encoder built from the R1 rule
  function automatic logic [7:0] benc(input logic [63:0] d);
    logic [7:0] c;
    c = 8'h0C;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
    return c;
  endfunction

  function automatic logic [7:0] bpar(input logic [63:0] d, input logic odd);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8] ^ odd;
    return p;
  endfunction

  task automatic apply(input logic [63:0] rd, input logic [7:0] rc, input logic c, input logic po);
    @(negedge clk);
    rd_data  = rd;
    rd_check = rc;
    ce       = c;
    podd     = po;
    @(posedge clk);
    #1;
  endtask

  // drive data d with syndrome s injected through the check byte
  task automatic sweep_one(input logic [63:0] d, input logic [7:0] s, input logic c, input logic po);
    int idx;
    int w;
    logic one_chk, e_dbl, e_multi;
    logic [63:0] exp_d;
    string tag;
    idx = -1;
    for (int i = 0; i < 64; i++) if (cols[i] == s) idx = i;
    w       = $countones(s);
    one_chk = (w == 1);
    e_dbl   = (s != 0) && (w % 2 == 0);
    e_multi = (w % 2 == 1) && (idx < 0) && !one_chk;
    exp_d   = (c && idx >= 0) ? (d ^ (64'd1 << idx)) : d;
    if (s == 0)        tag = "R3";
    else if (idx >= 0) tag = "R4";
    else if (one_chk)  tag = "R5";
    else if (e_dbl)    tag = "R6";
    else               tag = "R7";
    if (!c) tag = {tag, "/R8"};
    apply(d, benc(d) ^ s, c, po);
    check({tag, " syndrome"}, {56'd0, syndrome}, {56'd0, s});
    check({tag, " flags"}, {60'd0, err, merr, dbl, multi},
          {60'd0, s != 0, e_dbl | e_multi, e_dbl, e_multi});
    check({tag, " data"}, data_o, exp_d);
    check("R9 parity", {56'd0, parity}, {56'd0, bpar(exp_d, po)});
  endtask

  initial begin
    logic [63:0] pats [4];
    int n;
    n = 0;
    for (int v = 0; v < 256; v++) begin
      if ($countones(v[7:0]) % 2 == 1 && $countones(v[7:0]) >= 3 && n < 64) begin
        cols[n] = v[7:0];
        n++;
      end
    end
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hA5C3_0F96_5A3C_F069;
    pats[3] = 64'h0123_4567_89AB_CDEF;

    wr_data = '0; rd_data = '0; rd_check = 8'h0C; ce = 1'b1; podd = 1'b0;
    @(posedge clk); #1;
    // R2 all-zero write word
    check("R2 zero check byte", {56'd0, wr_check}, 64'h0C);
    check("R3 idle clean", {62'd0, err, merr}, 64'd0);

    // R1 single-bit and pattern write words
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); wr_data = 64'd1 << i; @(posedge clk); #1;
      check("R1 unit column", {56'd0, wr_check}, {56'd0, cols[i] ^ 8'h0C});
    end
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); wr_data = pats[p]; @(posedge clk); #1;
      check("R1 pattern", {56'd0, wr_check}, {56'd0, benc(pats[p])});
    end

    // R3..R9 every syndrome, both modes, both parity senses
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 256; s++)
        for (int m = 0; m < 2; m++)
          sweep_one(pats[p], s[7:0], m[0], s[0] ^ p[0]);

    // R4 real data-bit flips are repaired; R8 detect-only passes them
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 64; i++) begin
        apply(pats[p] ^ (64'd1 << i), benc(pats[p]), 1'b1, 1'b0);
        check("R4 repair", data_o, pats[p]);
        check("R4 flags", {62'd0, err, merr}, 64'd2);
        apply(pats[p] ^ (64'd1 << i), benc(pats[p]), 1'b0, 1'b1);
        check("R8 no repair", data_o, pats[p] ^ (64'd1 << i));
      end

    // R5 real check-bit flips
    for (int k = 0; k < 8; k++) begin
      apply(pats[2], benc(pats[2]) ^ (8'd1 << k), 1'b1, 1'b0);
      check("R5 check flip", {61'd0, err, merr, data_o == pats[2]}, 64'd5);
    end

    // R6 real double data flips
    for (int i = 0; i < 63; i++) begin
      apply(pats[3] ^ (64'd1 << i) ^ (64'd1 << (i + 1)), benc(pats[3]), 1'b1, 1'b0);
      check("R6 double", {60'd0, err, merr, dbl, multi}, 64'hE);
      check("R6 double data", data_o, pats[3] ^ (64'd1 << i) ^ (64'd1 << (i + 1)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule